// File: doc/BRIEF.md
# Card Reader Power-State Sequencer

This block sequences a multi-track magnetic card reader front end through its four operating phases: calibrate, sleep, swipe capture and host read-out. After power-up it issues a single calibration start pulse and waits for the analog side to acknowledge. A fixed cycle limit bounds that wait. It then turns the decode oscillator off and waits for swipe activity. Activity brings the oscillator back and enables the track decoders. The decoded bits are collected in a small internal bit store until every track reports completion or the store fills.

Once capture ends, the block pulls its serial data line low to tell the host that data is ready. The host then supplies a serial clock. Each falling edge of that clock places the next stored bit on the data line, and the host samples it on the following rising edge. One extra falling edge after the last bit sends the block back to calibration. The block runs on a slow always-on clock, because the decode oscillator is stopped during sleep. The swipe-activity level and the host clock are brought into that domain through two-flop synchronisers.

Top module: `card_power_seq`

## Requirements
- R1: While reset is held, and after it is released, the block is in the calibrate phase: oscEnable is 1, decodeEnable is 0, readEnd is 0 and dataOut is 1. calStart rises exactly once, for one clock cycle, shortly after reset is released.
- R2: A calDone pulse received after the calStart pulse moves the block to sleep in the next cycle. In sleep, oscEnable is 0 and decodeEnable is 0.
- R3: If calDone never arrives, the block moves to sleep exactly CAL_TIMEOUT cycles after calStart rises.
- R4: A high swipeActive level seen in sleep wakes the block once it has passed the synchroniser. oscEnable and decodeEnable are then both 1. The swipe phase is entered only from sleep.
- R5: In the swipe phase, every cycle with bitValid high stores bitData in arrival order. Bits offered during sleep or read-out are not stored.
- R6: When all trackDone bits are 1 during the swipe phase, the block enters read-out. readEnd goes to 1 and dataOut is held at 0 until the first falling edge of hostClk. After that edge, readEnd is 0.
- R7: In read-out, the n-th falling edge of hostClk drives stored bit n-1 onto dataOut, where bit 0 is the first bit captured. The value is held through the following rising edge.
- R8: The first falling edge of hostClk after the last stored bit has been presented returns the block to calibrate. dataOut returns to 1, and a new calStart pulse is issued.
- R9: When DEPTH bits have been stored, the swipe phase ends and read-out begins even if the tracks are not done. Further bits are dropped, so exactly DEPTH bits are read out.
- R10: A bit offered in the same cycle that the last track reports done is stored. It is read out as the final bit.
- R11: If only some of the trackDone bits are high, the swipe phase continues and decodeEnable stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| swipeActive | input | 1 | Swipe-activity level from the analog side, asynchronous |
| trackDone | input | NUM_TRACKS | Per-track decode-complete levels |
| bitValid | input | 1 | Decoder bit strobe |
| bitData | input | 1 | Decoded bit value |
| calDone | input | 1 | Calibration acknowledge |
| hostClk | input | 1 | Host serial clock, asynchronous |
| oscEnable | output | 1 | Decode oscillator enable, low only in sleep |
| decodeEnable | output | 1 | Track decoder enable, high only in swipe |
| calStart | output | 1 | One-cycle calibration start pulse |
| readEnd | output | 1 | Data-ready indication, high until the first host clock edge |
| dataOut | output | 1 | Serial data/control line value |

## Verification
Two events can land in the same cycle: the decoder's final bit strobe and the completion of the last track. The bench provokes this by raising the final trackDone bit on the same edge as the last bitValid. It judges the result by checking that the read-out ends with that bit and that the count of read-out edges before the return to calibration is unchanged. A second coincidence is the store filling while bits keep arriving. The bench streams DEPTH+3 bits back to back and expects exactly DEPTH bits from the host side.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;

  typedef enum logic [1:0] {
    PH_CAL     = 2'd0,
    PH_SLEEP   = 2'd1,
    PH_SWIPE   = 2'd2,
    PH_READOUT = 2'd3
  } seqPhase_t;

  // strobes from the control FSM to the bit datapath
  typedef struct packed {
    logic clrBuf;     // empty the store, line back to idle high
    logic capture;    // store the decoder bit of this cycle
    logic markReady;  // pull the line low: data ready
    logic shiftNext;  // present the next stored bit
  } dpStrobe_t;

endpackage

// File: rtl/cardseq_sync.sv
module cardseq_sync #(
  parameter int               WIDTH     = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageA;
  logic [WIDTH-1:0] stageB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA <= RESET_VAL;
      stageB <= RESET_VAL;
    end else begin
      stageA <= asyncIn;
      stageB <= stageA;
    end
  end

  assign syncOut = stageB;

endmodule

// File: rtl/cardseq_ctrl.sv
module cardseq_ctrl
  import cardseq_pkg::*;
#(
  parameter int CAL_TIMEOUT = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swipeSync,
  input  logic       allDone,
  input  logic       calDone,
  input  logic       hostFall,
  input  logic       bitValid,
  input  logic       bufFull,
  input  logic       readDone,
  output dpStrobe_t  strobes,
  output logic       oscEnable,
  output logic       decodeEnable,
  output logic       calStart,
  output logic       readEnd
);

  localparam int              TW         = $clog2(CAL_TIMEOUT + 1);
  localparam logic [TW-1:0]   TIMER_LAST = TW'(CAL_TIMEOUT - 1);

  seqPhase_t      phase;
  seqPhase_t      nextPhase;
  logic           calPending;
  logic           calStartQ;
  logic [TW-1:0]  calTimer;
  logic           edgeSeen;

  always_comb begin
    nextPhase = phase;
    strobes   = '0;
    unique case (phase)
      PH_CAL: begin
        if (!calPending && (calDone || calTimer == TIMER_LAST))
          nextPhase = PH_SLEEP;
      end
      PH_SLEEP: begin
        if (swipeSync)
          nextPhase = PH_SWIPE;
      end
      PH_SWIPE: begin
        strobes.capture = bitValid;
        if (bufFull || allDone) begin
          nextPhase         = PH_READOUT;
          strobes.markReady = 1'b1;
        end
      end
      PH_READOUT: begin
        if (hostFall) begin
          if (readDone) begin
            nextPhase      = PH_CAL;
            strobes.clrBuf = 1'b1;
          end else begin
            strobes.shiftNext = 1'b1;
          end
        end
      end
      default: nextPhase = PH_CAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_CAL;
      calPending <= 1'b1;
      calStartQ  <= 1'b0;
      calTimer   <= '0;
      edgeSeen   <= 1'b0;
    end else begin
      phase     <= nextPhase;
      calStartQ <= (phase == PH_CAL) && calPending;

      if (phase == PH_READOUT && nextPhase == PH_CAL)
        calPending <= 1'b1;
      else if (phase == PH_CAL)
        calPending <= 1'b0;

      if (phase == PH_CAL && calPending)
        calTimer <= '0;
      else if (phase == PH_CAL && calTimer != TIMER_LAST)
        calTimer <= calTimer + 1'b1;

      if (strobes.markReady)
        edgeSeen <= 1'b0;
      else if (phase == PH_READOUT && hostFall)
        edgeSeen <= 1'b1;
    end
  end

  assign oscEnable    = (phase != PH_SLEEP);
  assign decodeEnable = (phase == PH_SWIPE);
  assign calStart     = calStartQ;
  assign readEnd      = (phase == PH_READOUT) && !edgeSeen;

endmodule

// File: rtl/cardseq_datapath.sv
module cardseq_datapath
  import cardseq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobes,
  input  logic       bitData,
  output logic       bufFull,
  output logic       readDone,
  output logic       lineOut
);

  localparam int             CW         = $clog2(DEPTH + 1);
  localparam int             IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0]  FULL_COUNT = CW'(DEPTH);

  logic [DEPTH-1:0] bitStore;
  logic [CW-1:0]    wrCount;
  logic [CW-1:0]    rdPtr;
  logic             outBit;

  assign bufFull  = (wrCount == FULL_COUNT);
  assign readDone = (rdPtr == wrCount);
  assign lineOut  = outBit;

  always_ff @(posedge clk) begin
    if (strobes.capture && !bufFull)
      bitStore[wrCount[IW-1:0]] <= bitData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCount <= '0;
      rdPtr   <= '0;
      outBit  <= 1'b1;
    end else if (strobes.clrBuf) begin
      wrCount <= '0;
      rdPtr   <= '0;
      outBit  <= 1'b1;
    end else begin
      if (strobes.capture && !bufFull)
        wrCount <= wrCount + 1'b1;
      if (strobes.markReady)
        outBit <= 1'b0;
      else if (strobes.shiftNext && !readDone) begin
        outBit <= bitStore[rdPtr[IW-1:0]];
        rdPtr  <= rdPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import cardseq_pkg::*;
#(
  parameter int NUM_TRACKS  = 3,
  parameter int DEPTH       = 64,
  parameter int CAL_TIMEOUT = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  swipeActive,
  input  logic [NUM_TRACKS-1:0] trackDone,
  input  logic                  bitValid,
  input  logic                  bitData,
  input  logic                  calDone,
  input  logic                  hostClk,
  output logic                  oscEnable,
  output logic                  decodeEnable,
  output logic                  calStart,
  output logic                  readEnd,
  output logic                  dataOut
);

  logic [1:0] syncBus;
  logic       hostPrev;
  logic       hostFall;
  logic       bufFull;
  logic       readDone;
  dpStrobe_t  strobes;

  // bit 1: host clock (idle high), bit 0: swipe activity
  cardseq_sync #(.WIDTH(2), .RESET_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({hostClk, swipeActive}),
    .syncOut (syncBus)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostPrev <= 1'b1;
    else       hostPrev <= syncBus[1];
  end

  assign hostFall = hostPrev && !syncBus[1];

  cardseq_ctrl #(.CAL_TIMEOUT(CAL_TIMEOUT)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .swipeSync    (syncBus[0]),
    .allDone      (&trackDone),
    .calDone      (calDone),
    .hostFall     (hostFall),
    .bitValid     (bitValid),
    .bufFull      (bufFull),
    .readDone     (readDone),
    .strobes      (strobes),
    .oscEnable    (oscEnable),
    .decodeEnable (decodeEnable),
    .calStart     (calStart),
    .readEnd      (readEnd)
  );

  cardseq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bitData  (bitData),
    .bufFull  (bufFull),
    .readDone (readDone),
    .lineOut  (dataOut)
  );

endmodule

// File: rtl/card_power_seq_checker.sv
module card_power_seq_checker (
  input logic clk,
  input logic rstN,
  input logic oscEnable,
  input logic decodeEnable,
  input logic calStart,
  input logic readEnd,
  input logic dataOut
);

  p_cal_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> !calStart);

  p_recal_phase_r8: assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> (oscEnable && !decodeEnable && !readEnd));

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscEnable) |-> $past(!decodeEnable && !readEnd));

  p_decode_needs_osc_r4: assert property (@(posedge clk) disable iff (!rstN)
    decodeEnable |-> oscEnable);

  p_wake_from_sleep_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decodeEnable) |-> $past(!oscEnable));

  p_ready_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    readEnd |-> !dataOut);

  p_ready_after_swipe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readEnd) |-> $past(decodeEnable));

endmodule

bind card_power_seq card_power_seq_checker u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .oscEnable    (oscEnable),
  .decodeEnable (decodeEnable),
  .calStart     (calStart),
  .readEnd      (readEnd),
  .dataOut      (dataOut)
);

// File: tb/card_power_seq_test.sv
module card_power_seq_test;

  localparam int NT    = 3;
  localparam int DEPTH = 16;
  localparam int CALTO = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          swipeActive = 1'b0;
  logic [NT-1:0] trackDone = '0;
  logic          bitValid = 1'b0;
  logic          bitData = 1'b0;
  logic          calDone = 1'b0;
  logic          hostClk = 1'b1;
  logic          oscEnable, decodeEnable, calStart, readEnd, dataOut;

  int total = 0;
  int failed = 0;
  int calSeen = 0;

  always #5 clk = ~clk;

  card_power_seq #(.NUM_TRACKS(NT), .DEPTH(DEPTH), .CAL_TIMEOUT(CALTO)) uut (
    .clk(clk), .rstN(rstN), .swipeActive(swipeActive), .trackDone(trackDone),
    .bitValid(bitValid), .bitData(bitData), .calDone(calDone), .hostClk(hostClk),
    .oscEnable(oscEnable), .decodeEnable(decodeEnable), .calStart(calStart),
    .readEnd(readEnd), .dataOut(dataOut)
  );

  always @(negedge clk) if (rstN && calStart) calSeen <= calSeen + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic expBit(input int k, input int i);
    return logic'((((i * 5 + k * 11) >> 1) & 1) ^ ((i % 3 == 0) ? 1 : 0));
  endfunction

  // answer the pending calibration request with calDone
  task automatic calibrate(input int ref_cnt);
    while (calSeen <= ref_cnt) @(posedge clk);
    @(negedge clk) calDone = 1'b1;
    @(negedge clk) calDone = 1'b0;
    chk("R2 oscEnable in sleep", int'(oscEnable), 0);
    chk("R2 decodeEnable in sleep", int'(decodeEnable), 0);
  endtask

  task automatic hostPulse();
    @(negedge clk) hostClk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic hostRise();
    hostClk = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // mode 0: done after bits, 1: done with last bit, 2: overflow, 3: partial done first
  task automatic doSwipe(input int k, input int n, input int mode);
    int stored;
    int ref_cnt;
    stored = (n > DEPTH) ? DEPTH : n;
    // stray bits in sleep must not be stored (R5)
    repeat (2) begin
      @(negedge clk) begin bitValid = 1'b1; bitData = 1'b1; end
    end
    @(negedge clk) bitValid = 1'b0;
    swipeActive = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 oscEnable on wake", int'(oscEnable), 1);
    chk("R4 decodeEnable on wake", int'(decodeEnable), 1);
    swipeActive = 1'b0;
    if (mode == 3) begin
      trackDone = NT'((1 << (NT - 1)) - 1);
      repeat (4) @(negedge clk);
      chk("R11 partial done keeps swipe", int'(decodeEnable), 1);
    end
    for (int i = 0; i < n; i++) begin
      bitValid = 1'b1;
      bitData  = expBit(k, i);
      if (mode == 1 && i == n - 1) trackDone = '1;
      @(negedge clk);
    end
    bitValid = 1'b0;
    if (mode == 0 || mode == 3) trackDone = '1;
    repeat (3) @(negedge clk);
    chk((mode == 2) ? "R9 full forces readEnd" : "R6 readEnd raised", int'(readEnd), 1);
    chk("R6 line low while ready", int'(dataOut), 0);
    trackDone = '0;
    // late bits during read-out must be dropped (R5)
    @(negedge clk) begin bitValid = 1'b1; bitData = 1'b1; end
    @(negedge clk) bitValid = 1'b0;
    ref_cnt = calSeen;
    for (int i = 0; i < stored; i++) begin
      hostPulse();
      if (i == 0) chk("R6 readEnd cleared by first edge", int'(readEnd), 0);
      if (mode == 1 && i == stored - 1)
        chk("R10 coincident last bit", int'(dataOut), int'(expBit(k, i)));
      else
        chk((mode == 2) ? "R9 bit order" : "R7 bit order", int'(dataOut), int'(expBit(k, i)));
      hostRise();
      chk("R7 bit held past rise", int'(dataOut), int'(expBit(k, i)));
    end
    chk("R8 no recal before final edge", calSeen, ref_cnt);
    hostPulse();
    chk("R8 recal after final edge", calSeen, ref_cnt + 1);
    chk("R8 line idle high", int'(dataOut), 1);
    chk("R8 oscillator on", int'(oscEnable), 1);
    hostClk = 1'b1;
    calibrate(ref_cnt);
  endtask

  task automatic runAll();
    int cnt;
    repeat (3) @(negedge clk);
    chk("R1 reset calStart", int'(calStart), 0);
    chk("R1 reset oscEnable", int'(oscEnable), 1);
    chk("R1 reset decodeEnable", int'(decodeEnable), 0);
    chk("R1 reset readEnd", int'(readEnd), 0);
    chk("R1 reset dataOut", int'(dataOut), 1);
    rstN = 1'b1;
    // timeout path (R3): no calDone
    while (calSeen == 0) @(posedge clk);
    cnt = 0;
    while (oscEnable) begin
      @(negedge clk);
      cnt++;
      if (cnt > 4 * CALTO) break;
    end
    chk("R3 timeout cycles", cnt, CALTO);
    chk("R1 single calStart", calSeen, 1);
    for (int k = 0; k < DEPTH; k++)
      doSwipe(k, k, (k == 0) ? 0 : ((k % 3 == 2) ? 1 : ((k % 3 == 1) ? 3 : 0)));
    doSwipe(DEPTH, DEPTH + 3, 2);
    doSwipe(DEPTH + 1, DEPTH, 1);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule